// File: doc/BRIEF.md
# Internal Clock Source Mux-Divider

This block produces clock-enable pulses for six on-chip clock consumers. Each consumer owns a 5-bit field in one shared configuration register. The field does two jobs. It picks which of seven candidate tick streams drives the consumer: the auxiliary PLL stream or one of six frequency-generator streams. It also picks a small post-divide ratio. A select value of zero switches the consumer off.

The divide code is looked up in a fixed per-variant table. In the base variant the four codes give ratios 1, 4, 1 and 2. In the extended variant they give 1, 4, 3 and 2, so divide-by-3 exists only there. A consumer emits one single-cycle enable pulse for every N ticks of its selected stream, where N is the ratio. A new source or ratio takes effect only at the boundary of an output period, so the half-finished period is never cut short into a runt pulse. The register reads back exactly what was last written, and this includes the fields of consumers that are switched off.

Top module: `ics_mux_div`

## Requirements
- R1: After a synchronous reset, the configuration register reads zero and every consumer enable stays low.
- R2: Register readback returns the last value written, bit for bit, including the fields of disabled consumers.
- R3: Consumer n uses register bits [5n+4:5n]. Within that field, bits [1:0] hold the divide code and bits [4:2] hold the source select.
- R4: A source select of 0 disables the consumer, and its enable output never pulses.
- R5: Select value 1 routes src_tick[0] (the auxiliary PLL stream). Select values 2 to 7 route src_tick[1] to src_tick[6] (frequency generators 0 to 5). The consumer ignores ticks on every other stream.
- R6: In the base variant (EXT_VARIANT=0), divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2. The consumer emits one pulse per that many selected ticks.
- R7: In the extended variant (EXT_VARIANT=1), divide codes 0, 1, 2 and 3 give ratios 1, 4, 3 and 2. Only the extended variant ever divides by 3.
- R8: The enable pulse is high for exactly the one cycle after the cycle that carries the period's last selected tick.
- R9: A write that changes a consumer's source or ratio while an output period is in progress does not affect that period. The new setting applies from the next period onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration register |
| cfg_wr_data | input | NUM_CONS*5 | Value to write into the configuration register |
| cfg_rd_data | output | NUM_CONS*5 | Current contents of the configuration register |
| src_tick | input | NUM_GEN+1 | Candidate tick streams: bit 0 is the auxiliary PLL, bits 1 and up are the generators |
| cons_en | output | NUM_CONS | One clock-enable pulse output per consumer |

## Verification
Both variants share the same stimulus, and the tests check them side by side.

- **Continuous ticks.** The stream ticks every cycle and then every other cycle. This tells the ratio tables apart: code 2 yields a third as many pulses in the extended variant as in the base variant.
- **Source selection.** Each select value is driven first with ticks on its own stream only, then on every other stream. This separates correct routing from an off-by-one stream index.
- **Single ticks.** Isolated ticks pin the exact cycle of each pulse.
- **Mid-period write.** A write lands partway through a divide-by-4 period. The pulse count that follows tells a boundary-aligned update apart from an immediate one.

// File: rtl/ics_pkg.sv
package ics_pkg;

    localparam int FIELD_W = 5;
    localparam int SEL_W   = 3;
    localparam int CODE_W  = 2;
    localparam int CNT_W   = 2;

    typedef struct packed {
        logic [SEL_W-1:0]  src;
        logic [CODE_W-1:0] code;
    } ics_field_t;

    // Last count value of an output period (ratio minus one).
    function automatic logic [CNT_W-1:0] period_last(input logic [CODE_W-1:0] code,
                                                      input bit ext);
        logic [CNT_W-1:0] r;
        case (code)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd3;
            2'd2:    r = ext ? 2'd2 : 2'd0;
            default: r = 2'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ics_cfg_reg.sv
module ics_cfg_reg #(
    parameter int WIDTH = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_data;
    end

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == $past(wr_data)));

endmodule

// File: rtl/ics_consumer.sv
module ics_consumer
    import ics_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter bit EXT     = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  ics_field_t         field,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               out_en
);

    ics_field_t       act;
    ics_field_t       eff;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             tick;

    // New settings are taken only at a period boundary (count at zero).
    always_comb begin
        eff  = (cnt == '0) ? field : act;
        last = period_last(eff.code, EXT);
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eff.src == SEL_W'(i + 1)) tick = src_tick[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= '0;
            cnt    <= '0;
            out_en <= 1'b0;
        end else begin
            act <= eff;
            if (tick && cnt == last) begin
                cnt    <= '0;
                out_en <= 1'b1;
            end else begin
                out_en <= 1'b0;
                if (tick) cnt <= cnt + 1'b1;
            end
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    // R7
    no_div3_chk: assert property (@(posedge clk) disable iff (rst)
        !(EXT == 1'b0 && last == 2'd2));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(act));

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (field.src == '0 && cnt == '0) |=> !out_en);

    // R8
    unit_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && last == '0) |=> out_en);

endmodule

// File: rtl/ics_mux_div.sv
module ics_mux_div
    import ics_pkg::*;
#(
    parameter int NUM_CONS    = 6,
    parameter int NUM_GEN     = 6,
    parameter bit EXT_VARIANT = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_wr_en,
    input  logic [NUM_CONS*FIELD_W-1:0]   cfg_wr_data,
    output logic [NUM_CONS*FIELD_W-1:0]   cfg_rd_data,
    input  logic [NUM_GEN:0]              src_tick,
    output logic [NUM_CONS-1:0]           cons_en
);

    localparam int REG_W   = NUM_CONS * FIELD_W;
    localparam int NUM_SRC = NUM_GEN + 1;

    logic [REG_W-1:0] cfg_q;

    ics_cfg_reg #(.WIDTH(REG_W)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .q       (cfg_q)
    );

    assign cfg_rd_data = cfg_q;

    for (genvar g = 0; g < NUM_CONS; g++) begin : g_cons
        ics_field_t fld;
        assign fld = ics_field_t'(cfg_q[FIELD_W*g +: FIELD_W]);

        ics_consumer #(.NUM_SRC(NUM_SRC), .EXT(EXT_VARIANT)) cons_i (
            .clk      (clk),
            .rst      (rst),
            .field    (fld),
            .src_tick (src_tick),
            .out_en   (cons_en[g])
        );
    end

endmodule

// File: tb/ics_mux_div_tb.sv
`timescale 1ns/1ps
module ics_mux_div_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [29:0] wr_data = '0;
    logic [29:0] rd_b, rd_x;
    logic [6:0]  src = '0;
    logic [5:0]  en_b, en_x;

    int n_chk = 0;
    int n_bad = 0;
    int pc_b[6];
    int pc_x[6];
    int got_b[6];
    int got_x[6];

    always #10 clk = ~clk;

    ics_mux_div #(.EXT_VARIANT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
        .cfg_rd_data(rd_b), .src_tick(src), .cons_en(en_b));

    ics_mux_div #(.EXT_VARIANT(1'b1)) dut_x (
        .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
        .cfg_rd_data(rd_x), .src_tick(src), .cons_en(en_x));

    initial for (int i = 0; i < 6; i++) begin pc_b[i] = 0; pc_x[i] = 0; end

    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            pc_b[i] += int'(en_b[i]);
            pc_x[i] += int'(en_x[i]);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] fld(input int s, input int c);
        return {3'(s), 2'(c)};
    endfunction

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic do_reset();
        cyc(); rst = 1'b1; wr_en = 1'b0; src = '0;
        repeat (3) cyc();
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [29:0] v);
        cyc(); wr_en = 1'b1; wr_data = v;
        cyc(); wr_en = 1'b0;
    endtask

    // n ticks on mask m, one every gap cycles, then idle; counts pulses per consumer.
    task automatic run_ticks(input logic [6:0] m, input int n, input int gap);
        int sb[6];
        int sx[6];
        for (int i = 0; i < 6; i++) begin sb[i] = pc_b[i]; sx[i] = pc_x[i]; end
        for (int k = 0; k < n; k++) begin
            cyc(); src = m;
            for (int g = 1; g < gap; g++) begin cyc(); src = '0; end
        end
        cyc(); src = '0;
        repeat (3) cyc();
        for (int i = 0; i < 6; i++) begin
            got_b[i] = pc_b[i] - sb[i];
            got_x[i] = pc_x[i] - sx[i];
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset readback", int'(rd_b), 0);
        run_ticks(7'h7f, 16, 1);
        for (int i = 0; i < 6; i++) check("R1 R4 pulses after reset", got_b[i], 0);
    endtask

    task automatic t_readback();
        logic [29:0] v;
        do_reset();
        v = {fld(0, 3), fld(5, 2), fld(0, 1), fld(7, 3), fld(1, 1), fld(2, 0)};
        write_cfg(v);
        check("R2 readback word", int'(rd_b), int'(v));
        check("R3 disabled field 5 kept", int'(rd_b[29:25]), 3);
        run_ticks(7'h7f, 8, 1);
        check("R4 disabled consumer 5 quiet", got_b[5], 0);
        check("R4 disabled consumer 3 quiet", got_b[3], 0);
    endtask

    task automatic t_select();
        for (int s = 1; s <= 7; s++) begin
            do_reset();
            write_cfg({15'd0, fld(s, 0), 10'd0});
            run_ticks(7'(1 << (s - 1)), 8, 1);
            check($sformatf("R5 R3 sel %0d own stream", s), got_b[2], 8);
            check($sformatf("R5 sel %0d others silent", s), got_b[0] + got_b[1], 0);
            run_ticks(~7'(1 << (s - 1)), 8, 1);
            check($sformatf("R5 sel %0d foreign streams", s), got_b[2], 0);
        end
    endtask

    task automatic t_ratio(input int gap, input int n);
        int eb[6];
        int ex[6];
        do_reset();
        write_cfg({fld(7, 3), fld(2, 1), fld(1, 3), fld(1, 2), fld(1, 1), fld(1, 0)});
        run_ticks(7'h7f, n, gap);
        eb = '{n, n / 4, n, n / 2, n / 4, n / 2};
        ex = '{n, n / 4, n / 3, n / 2, n / 4, n / 2};
        for (int i = 0; i < 6; i++) begin
            check($sformatf("R6 base consumer %0d gap %0d", i, gap), got_b[i], eb[i]);
            check($sformatf("R7 ext consumer %0d gap %0d", i, gap), got_x[i], ex[i]);
        end
    endtask

    task automatic t_timing();
        do_reset();
        write_cfg({25'd0, fld(1, 0)});
        cyc(); src = 7'h01;
        check("R8 no pulse in tick cycle", int'(en_b[0]), 0);
        cyc(); src = '0;
        check("R8 pulse cycle after tick", int'(en_b[0]), 1);
        cyc();
        check("R8 pulse one cycle wide", int'(en_b[0]), 0);
        write_cfg({25'd0, fld(1, 1)});
        for (int k = 0; k < 3; k++) begin cyc(); src = 7'h01; end
        cyc(); src = 7'h01;
        check("R8 no pulse before 4th tick", int'(en_b[0]), 0);
        cyc(); src = '0;
        check("R8 pulse after 4th tick", int'(en_b[0]), 1);
        cyc();
        check("R8 pulse ends", int'(en_b[0]), 0);
    endtask

    task automatic t_boundary();
        do_reset();
        write_cfg({25'd0, fld(1, 1)});
        run_ticks(7'h01, 2, 1);
        check("R9 no pulse mid period", got_b[0], 0);
        write_cfg({25'd0, fld(1, 0)});
        run_ticks(7'h01, 2, 1);
        check("R9 old ratio finishes period", got_b[0], 1);
        run_ticks(7'h01, 3, 1);
        check("R9 new ratio after boundary", got_b[0], 3);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_select();
        t_ratio(1, 24);
        t_ratio(2, 12);
        t_timing();
        t_boundary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule